// File: doc/BRIEF.md
# Bus Master Arbitration Handshake

This block wins and gives back ownership of a shared, open-collector parallel system bus on behalf of one bus master. The local transfer logic raises a request level. The block then asks for the bus with an active-low request line, which serves parallel priority resolution. At the same time it raises its priority-out line, which serves a serial daisy chain. It takes the bus only when the priority-in line is low and no other master is driving the shared busy line. When it takes the bus it pulls busy low and enables the address drivers together.

A done pulse from the transfer logic starts the release. The release happens in a fixed order: the address enable goes first, then the request and priority-out lines, and the busy line last. A lock input can cut the release short. With lock held, the block drops only the address enable and keeps busy pulled low, so the next byte of a multibyte sequence starts again without arbitration. All bus lines change only in the system clock cycle that follows a falling edge of the bus clock. The bus clock is sampled in the system clock domain. Priority-in and the shared busy line pass through a synchronizer of configurable depth.

Top module: `bus_arb_handshake`

## Requirements
- R1: During and right after reset the outputs are req_bus_n=1, pri_out_n=0, busy_drive=0, addr_en_n=1 and owned=0.
- R2: In the idle phase, a high xfer_req seen at a bus clock falling edge drives req_bus_n low and pri_out_n high. While req_bus_n is low, pri_out_n is high.
- R3: The master takes the bus (busy_drive goes 1) only at a bus clock falling edge where the synchronized pri_in_n is 0 and the synchronized busy_line_n is 1. Each of these inputs is delayed by SYNC_STAGES (default 2) system clock flops.
- R4: On taking the bus, busy_drive goes to 1 and addr_en_n goes to 0 in the same cycle.
- R5: While waiting without a grant, req_bus_n stays 0, busy_drive stays 0 and addr_en_n stays 1. This includes the case where pri_in_n is high.
- R6: After xfer_done without lock, the outputs change at three successive bus clock falling edges. First addr_en_n goes to 1. Next req_bus_n goes to 1 and pri_out_n goes to 0. Last busy_drive goes to 0.
- R7: If lock is 1 when the done is acted on, the block sets only addr_en_n to 1 and keeps busy_drive=1 and req_bus_n=0. A later xfer_req sets addr_en_n back to 0 at the next falling edge, whatever the state of pri_in_n.
- R8: When the bus is held under lock with no request pending, dropping lock gives req_bus_n=1 and pri_out_n=0 at one falling edge and busy_drive=0 at the next. addr_en_n stays 1 throughout.
- R9: owned is 1 exactly while addr_en_n is 0.
- R10: The bus-side outputs change only in the cycle after a system clock edge at which the bus clock was seen going from 1 to 0.
- R11: An xfer_done pulse given while the block does not own the bus has no effect. Ownership taken later lasts until a new done arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bus clock, sampled on clk |
| xfer_req | input | 1 | Transfer request level from the transfer logic |
| xfer_done | input | 1 | One-cycle pulse: transfer acknowledged |
| lock | input | 1 | Keep ownership between transfers |
| pri_in_n | input | 1 | Priority-in, active low |
| busy_line_n | input | 1 | Shared busy line as sampled, active low |
| req_bus_n | output | 1 | Bus request for parallel priority, active low |
| pri_out_n | output | 1 | Priority-out for the serial chain, active low |
| busy_drive | output | 1 | Enable to pull the shared busy line low |
| addr_en_n | output | 1 | Address driver enable, active low |
| owned | output | 1 | High while this master drives the address bus |

## Verification
The bench goes after the cases where a weak handshake slips. It withholds priority for a long time: a design that took the bus early would collide with another master. It holds a foreign busy: a design that ignored the busy line would drive over another owner. It gives a done before ownership: a design that kept that pulse would release the bus at once after the grant. It checks the teardown order: a design that dropped request or busy before the address enable would leave the address drivers on a bus that is already free. It checks lock in both directions: a design that ignored lock would lose the bus between bytes, and one that kept the bus after lock was removed would never return it. It also freezes the bus clock, so a design that changed its lines on the system clock alone would show a step.

// File: rtl/abh_pkg.sv
package abh_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_ASK     = 3'd1,
      PH_HOLD    = 3'd2,
      PH_DROP_AE = 3'd3,
      PH_DROP_RQ = 3'd4,
      PH_PARKED  = 3'd5
   } abh_phase_e;

   typedef struct packed {
      logic req_n;
      logic pro_n;
      logic busy;
      logic aen_n;
   } abh_lines_s;

   function automatic abh_lines_s abh_decode(input abh_phase_e ph);
      abh_lines_s l;
      unique case (ph)
         PH_IDLE:    l = '{req_n: 1'b1, pro_n: 1'b0, busy: 1'b0, aen_n: 1'b1};
         PH_ASK:     l = '{req_n: 1'b0, pro_n: 1'b1, busy: 1'b0, aen_n: 1'b1};
         PH_HOLD:    l = '{req_n: 1'b0, pro_n: 1'b1, busy: 1'b1, aen_n: 1'b0};
         PH_DROP_AE: l = '{req_n: 1'b0, pro_n: 1'b1, busy: 1'b1, aen_n: 1'b1};
         PH_DROP_RQ: l = '{req_n: 1'b1, pro_n: 1'b0, busy: 1'b1, aen_n: 1'b1};
         PH_PARKED:  l = '{req_n: 1'b0, pro_n: 1'b1, busy: 1'b1, aen_n: 1'b1};
         default:    l = '{req_n: 1'b1, pro_n: 1'b0, busy: 1'b0, aen_n: 1'b1};
      endcase
      return l;
   endfunction

endpackage

// File: rtl/abh_sync.sv
module abh_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("abh_sync: STAGES must lie in 0..4");
      end
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {STAGES{RST_VAL}};
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/abh_fall_det.sv
module abh_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   output logic fall
);
   logic bclk_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk;
   end
   assign fall = bclk_q & ~bclk;
endmodule

// File: rtl/abh_ctrl.sv
module abh_ctrl
   import abh_pkg::*;
#(
   parameter bit LOCK_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fall,
   input  logic       xfer_req,
   input  logic       xfer_done,
   input  logic       lock,
   input  logic       pri_s_n,
   input  logic       busy_s_n,
   output abh_phase_e phase
);
   abh_phase_e nxt;
   logic       done_pend;
   logic       done_seen;
   logic       lock_eff;
   logic       grant;

   assign lock_eff  = lock & LOCK_SUPPORT;
   assign grant     = ~pri_s_n & busy_s_n;
   assign done_seen = done_pend | xfer_done;

   always_comb begin
      nxt = phase;
      if (fall) begin
         unique case (phase)
            PH_IDLE:    if (xfer_req) nxt = PH_ASK;
            PH_ASK:     if (grant) nxt = PH_HOLD;
            PH_HOLD:    if (done_seen) nxt = lock_eff ? PH_PARKED : PH_DROP_AE;
            PH_DROP_AE: nxt = PH_DROP_RQ;
            PH_DROP_RQ: nxt = PH_IDLE;
            PH_PARKED: begin
               if (xfer_req)      nxt = PH_HOLD;
               else if (!lock_eff) nxt = PH_DROP_RQ;
            end
            default:    nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         done_pend <= 1'b0;
      end else begin
         phase     <= nxt;
         done_pend <= (phase == PH_HOLD) && (nxt == PH_HOLD) && done_seen;
      end
   end
endmodule

// File: rtl/bus_arb_handshake.sv
module bus_arb_handshake
   import abh_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter bit LOCK_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic xfer_req,
   input  logic xfer_done,
   input  logic lock,
   input  logic pri_in_n,
   input  logic busy_line_n,
   output logic req_bus_n,
   output logic pri_out_n,
   output logic busy_drive,
   output logic addr_en_n,
   output logic owned
);
   logic       bclk_fall;
   logic       pri_sync_n;
   logic       busy_sync_n;
   abh_phase_e phase;
   abh_lines_s lines;

   abh_fall_det u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .bclk (bclk),
      .fall (bclk_fall)
   );

   abh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pri (
      .clk(clk), .rst_n(rst_n), .d(pri_in_n), .q(pri_sync_n)
   );

   abh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_busy (
      .clk(clk), .rst_n(rst_n), .d(busy_line_n), .q(busy_sync_n)
   );

   abh_ctrl #(.LOCK_SUPPORT(LOCK_SUPPORT)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall     (bclk_fall),
      .xfer_req (xfer_req),
      .xfer_done(xfer_done),
      .lock     (lock),
      .pri_s_n  (pri_sync_n),
      .busy_s_n (busy_sync_n),
      .phase    (phase)
   );

   assign lines      = abh_decode(phase);
   assign req_bus_n  = lines.req_n;
   assign pri_out_n  = lines.pro_n;
   assign busy_drive = lines.busy;
   assign addr_en_n  = lines.aen_n;
   assign owned      = (phase == PH_HOLD);
endmodule

// File: rtl/abh_chk.sv
module abh_chk (
   input logic clk,
   input logic rst_n,
   input logic fall,
   input logic pri_s_n,
   input logic busy_s_n,
   input logic req_bus_n,
   input logic pri_out_n,
   input logic busy_drive,
   input logic addr_en_n,
   input logic owned
);
   // R2
   req_pro_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_bus_n |-> !pri_out_n == 1'b0);

   // R3
   take_when_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_drive) |-> ($past(pri_s_n) == 1'b0 && $past(busy_s_n) == 1'b1));

   // R4
   aen_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(addr_en_n) |-> busy_drive);

   // R6
   req_after_aen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_bus_n) |-> (addr_en_n && busy_drive));

   // R6
   busy_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_drive) |-> (addr_en_n && req_bus_n && !pri_out_n));

   // R9
   owned_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      owned |-> (busy_drive && !req_bus_n));

   // R10
   bus_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable({req_bus_n, pri_out_n, busy_drive, addr_en_n}));
endmodule

bind bus_arb_handshake abh_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fall      (bclk_fall),
   .pri_s_n   (pri_sync_n),
   .busy_s_n  (busy_sync_n),
   .req_bus_n (req_bus_n),
   .pri_out_n (pri_out_n),
   .busy_drive(busy_drive),
   .addr_en_n (addr_en_n),
   .owned     (owned)
);

// File: tb/tb_bus_arb_handshake.sv
module tb_bus_arb_handshake;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0;
   logic bclk_run = 1'b1;
   logic xfer_req = 1'b0;
   logic xfer_done = 1'b0;
   logic lock = 1'b0;
   logic pri_in_n = 1'b1;
   logic other_busy = 1'b0;
   logic rnd_on = 1'b0;
   logic busy_line_n;
   logic req_bus_n, pri_out_n, busy_drive, addr_en_n, owned;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign busy_line_n = ~(busy_drive | other_busy);

   bus_arb_handshake dut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .xfer_req(xfer_req),
      .xfer_done(xfer_done), .lock(lock), .pri_in_n(pri_in_n),
      .busy_line_n(busy_line_n), .req_bus_n(req_bus_n), .pri_out_n(pri_out_n),
      .busy_drive(busy_drive), .addr_en_n(addr_en_n), .owned(owned)
   );

   // reference model built from the requirements (phase codes are bench-local)
   localparam int M_IDLE = 0, M_ASK = 1, M_OWN = 2, M_REL1 = 3, M_REL2 = 4, M_LOCK = 5;
   int   ms;
   logic mdone, mp1, mp2, mb1, mb2, mbq;
   logic mfall;
   assign mfall = mbq & ~bclk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms <= M_IDLE; mdone <= 1'b0;
         mp1 <= 1'b1; mp2 <= 1'b1; mb1 <= 1'b0; mb2 <= 1'b0; mbq <= 1'b0;
      end else begin
         mp1 <= pri_in_n; mp2 <= mp1; mb1 <= busy_line_n; mb2 <= mb1; mbq <= bclk;
         mdone <= 1'b0;
         if (ms == M_OWN && (mdone || xfer_done) && !mfall) mdone <= 1'b1;
         if (mfall) begin
            case (ms)
               M_IDLE: if (xfer_req) ms <= M_ASK;
               M_ASK:  if (mp2 == 1'b0 && mb2 == 1'b1) ms <= M_OWN;
               M_OWN:  if (mdone || xfer_done) ms <= lock ? M_LOCK : M_REL1;
               M_REL1: ms <= M_REL2;
               M_REL2: ms <= M_IDLE;
               M_LOCK: if (xfer_req) ms <= M_OWN; else if (!lock) ms <= M_REL2;
               default: ms <= M_IDLE;
            endcase
         end
      end
   end

   function automatic logic [4:0] expect_lines(input int s);
      // {req_bus_n, pri_out_n, busy_drive, addr_en_n, owned}
      case (s)
         M_ASK:  return 5'b01010;
         M_OWN:  return 5'b01101;
         M_REL1: return 5'b01110;
         M_REL2: return 5'b10110;
         M_LOCK: return 5'b01110;
         default: return 5'b10010;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [4:0] e;
         e = expect_lines(ms);
         chk(req_bus_n  == e[4], "R2", "req_bus_n",  int'(req_bus_n),  int'(e[4]));
         chk(pri_out_n  == e[3], "R6", "pri_out_n",  int'(pri_out_n),  int'(e[3]));
         chk(busy_drive == e[2], "R3", "busy_drive", int'(busy_drive), int'(e[2]));
         chk(addr_en_n  == e[1], "R4", "addr_en_n",  int'(addr_en_n),  int'(e[1]));
         chk(owned      == e[0], "R9", "owned",      int'(owned),      int'(e[0]));
      end
   end

   // bus clock: period of six system clocks, can be frozen
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         if (bclk_run) bclk = ~bclk;
      end
   end

   // random environment: priority and a foreign bus owner
   initial begin
      forever begin
         @(negedge clk);
         if (rnd_on) begin
            if ($urandom % 7 == 0) pri_in_n = ($urandom % 3 == 0);
            if (req_bus_n && $urandom % 9 == 0) other_busy = $urandom % 2;
            else if (!req_bus_n && other_busy && $urandom % 6 == 0) other_busy = 1'b0;
         end
      end
   end

   task automatic wait_owned(input string req);
      int n = 0;
      while (!owned && n < 600) begin @(negedge clk); n++; end
      chk(owned == 1'b1, req, "ownership reached", int'(owned), 1);
   endtask

   task automatic finish_run;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1d2c_3b4a));
      repeat (3) @(negedge clk);
      // R1 reset values
      chk({req_bus_n, pri_out_n, busy_drive, addr_en_n, owned} == 5'b10010, "R1",
          "reset lines", int'({req_bus_n, pri_out_n, busy_drive, addr_en_n, owned}), 5'b10010);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk({req_bus_n, pri_out_n, busy_drive, addr_en_n, owned} == 5'b10010, "R1",
          "lines after reset", int'({req_bus_n, pri_out_n, busy_drive, addr_en_n, owned}), 5'b10010);

      // R10: frozen bus clock blocks any change
      bclk_run = 1'b0;
      repeat (2) @(negedge clk);
      xfer_req = 1'b1;
      repeat (30) @(negedge clk);
      chk(req_bus_n == 1'b1, "R10", "req held while bus clock stopped", int'(req_bus_n), 1);
      bclk_run = 1'b1;

      // R2 and R5: request without priority, then a stray done (R11)
      repeat (20) @(negedge clk);
      chk(req_bus_n == 1'b0 && pri_out_n == 1'b1, "R2", "request lines",
          int'({req_bus_n, pri_out_n}), 1);
      xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
      repeat (40) @(negedge clk);
      chk(!req_bus_n && !busy_drive && addr_en_n, "R5", "still waiting without priority",
          int'({req_bus_n, busy_drive, addr_en_n}), 1);
      pri_in_n = 1'b0;
      wait_owned("R4");
      chk(busy_drive && !addr_en_n, "R4", "busy and aen together", int'({busy_drive, addr_en_n}), 2);
      repeat (30) @(negedge clk);
      chk(owned == 1'b1, "R11", "stray done ignored", int'(owned), 1);

      // R6 teardown order
      begin
         int t_aen = -1, t_req = -1, t_busy = -1;
         xfer_done = 1'b1; xfer_req = 1'b0;
         @(negedge clk); xfer_done = 1'b0;
         for (int i = 0; i < 60; i++) begin
            if (t_aen  < 0 && addr_en_n)   t_aen  = i;
            if (t_req  < 0 && req_bus_n)   t_req  = i;
            if (t_busy < 0 && !busy_drive) t_busy = i;
            @(negedge clk);
         end
         chk(t_aen >= 0 && t_aen < t_req, "R6", "aen before request", t_aen, t_req);
         chk(t_req < t_busy, "R6", "request before busy", t_req, t_busy);
         chk(t_busy - t_req == 6, "R6", "busy one bus clock after request", t_busy - t_req, 6);
      end

      // R3: a foreign owner holds busy
      other_busy = 1'b1;
      xfer_req = 1'b1;
      repeat (50) @(negedge clk);
      chk(busy_drive == 1'b0, "R3", "no take while line busy", int'(busy_drive), 0);
      other_busy = 1'b0;
      wait_owned("R3");

      // R7: lock keeps the bus between bytes, no grant needed
      lock = 1'b1;
      xfer_done = 1'b1; xfer_req = 1'b0; @(negedge clk); xfer_done = 1'b0;
      pri_in_n = 1'b1;
      repeat (30) @(negedge clk);
      chk(busy_drive && addr_en_n && !req_bus_n, "R7", "parked under lock",
          int'({busy_drive, addr_en_n, req_bus_n}), 6);
      xfer_req = 1'b1;
      repeat (13) @(negedge clk);
      chk(owned == 1'b1, "R7", "reuse without arbitration", int'(owned), 1);
      xfer_done = 1'b1; xfer_req = 1'b0; @(negedge clk); xfer_done = 1'b0;
      repeat (20) @(negedge clk);

      // R8: lock dropped while parked
      begin
         int t_req = -1, t_busy = -1;
         bit aen_hi = 1'b1;
         lock = 1'b0;
         for (int i = 0; i < 40; i++) begin
            if (!addr_en_n) aen_hi = 1'b0;
            if (t_req  < 0 && req_bus_n)   t_req  = i;
            if (t_busy < 0 && !busy_drive) t_busy = i;
            @(negedge clk);
         end
         chk(t_req >= 0 && t_busy - t_req == 6, "R8", "request then busy release", t_busy - t_req, 6);
         chk(aen_hi, "R8", "aen stays high", int'(aen_hi), 1);
      end

      // constrained random transfers
      rnd_on = 1'b1;
      for (int k = 0; k < 80; k++) begin
         lock = ($urandom % 3 == 0);
         xfer_req = 1'b1;
         wait_owned("R3");
         repeat ($urandom % 20) @(negedge clk);
         xfer_done = 1'b1; xfer_req = 1'b0;
         @(negedge clk); xfer_done = 1'b0;
         repeat ($urandom % 25) @(negedge clk);
         if ($urandom % 2 == 0) lock = 1'b0;
      end
      rnd_on = 1'b0;
      lock = 1'b0; other_busy = 1'b0;
      repeat (40) @(negedge clk);
      chk({req_bus_n, pri_out_n, busy_drive, addr_en_n, owned} == 5'b10010, "R8",
          "idle after random run", int'({req_bus_n, pri_out_n, busy_drive, addr_en_n, owned}), 5'b10010);
      finish_run();
   end
endmodule